// File: doc/BRIEF.md
# Device Power-State Controller

This block sequences one managed device through five power states: running, clock-gated idle, a timed power-down, unpowered sleep and a timed power-up. A request line reports demand. When demand stops, the block either waits out an idle time-out or, under a predictive policy, decides at once from the length of the busy stretch that just ended. The time-out can be a fixed programmed value. It can also be a value the block retunes after every idle stretch, based on how long that stretch lasted.

Power-down and power-up both take a programmed number of cycles, and the device is unusable during either one. Demand that shows up while the device is powering down is latched. The power-up sequence then starts as soon as the power-down interval ends. All limits are cycle counts presented on configuration inputs. The clock-enable, power-enable and ready outputs are decoded from the current state.

Top module: `dpm_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the block in RUN (state code 0), with clock enable, power enable and ready all at 1.
- R2: The state codes are RUN=0, IDLE=1, SHUT=2, SLEEP=3 and WAKE=4. Clock enable is 1 only in RUN. Power enable is 0 only in SLEEP. Ready is 1 only in RUN.
- R3: In time-out mode (policy 0), RUN moves to IDLE on the first edge that sees the request low. If the request stays low, IDLE lasts exactly τ cycles and is then followed by SHUT. A τ of 0 acts as 1.
- R4: A request seen in IDLE returns the block to RUN on the next edge, with no power-up delay.
- R5: SHUT lasts exactly the power-down count in cycles (0 acts as 1). If no request arrived during it, SLEEP follows.
- R6: From SLEEP, a wake event or a request moves the block to WAKE on the next edge. WAKE lasts exactly the power-up count in cycles, and RUN follows it.
- R7: A request seen at any edge during SHUT is held. SHUT still runs its full length, ready stays 0, and WAKE follows SHUT directly, even if the request has since dropped.
- R8: In predictive mode (policy 1), when the request drops after a busy run shorter than θ cycles, RUN moves straight to SHUT.
- R9: In predictive mode, when the busy run reaches θ or more cycles, RUN moves to IDLE. IDLE then never times out and waits for a request.
- R10: With adaptive mode on, each return to RUN doubles τ if the non-running stretch that just ended was shorter than the breakeven count. The doubled value is capped at the upper bound.
- R11: With adaptive mode on, each return to RUN halves τ if the stretch was longer than 2τ. The halved value is raised to the lower bound if it falls below it. With adaptive mode off, τ follows the configured value.
- R12: The busy-run counter and the non-running counter hold at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Device demand (busy request / interrupt) |
| wake_i | input | 1 | Wake event that ends SLEEP |
| policy_i | input | 1 | 0 = time-out policy, 1 = predictive policy |
| adapt_i | input | 1 | 1 = run-time adjustment of τ |
| tau_i | input | CW | Idle time-out τ in cycles (fixed value, or start value for adaptation) |
| tau_min_i | input | CW | Lower bound of adaptive τ |
| tau_max_i | input | CW | Upper bound of adaptive τ |
| brk_i | input | CW | Breakeven stretch length in cycles |
| theta_i | input | CW | Predictive busy-run threshold θ |
| tsd_i | input | CW | Power-down interval in cycles |
| twu_i | input | CW | Power-up interval in cycles |
| clk_en_o | output | 1 | Device clock enable |
| pwr_en_o | output | 1 | Device power enable |
| state_o | output | 3 | Current state code |
| ready_o | output | 1 | Device usable |

## Verification
The properties assume that the configuration inputs stay steady while the device is outside RUN, and that the lower bound on τ never exceeds the upper bound. The bound property in particular relies on the limits present at the moment τ is updated. The stimulus changes the policy, adaptive mode and θ only while the request is held high in RUN, and never changes the time-out limits. The wake event is kept to single-cycle pulses given only in SLEEP, so each transition sees one cause at a time.

// File: rtl/dpm_pkg.sv
// Shared types for the device power-state controller.
// Assumes: state codes are visible at the block output and must stay fixed.
package dpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_SHUT  = 3'd2,
        ST_SLEEP = 3'd3,
        ST_WAKE  = 3'd4
    } dpm_state_e;

endpackage

// File: rtl/dpm_sat_ctr.sv
// Saturating up-counter with a clear that takes priority over counting.
// Assumes: clr and inc are synchronous to clk. The count holds at all ones.
module dpm_sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    // Count register: clear, step, or hold at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dpm_tau_adapt.sv
// Holds the idle time-out. In fixed mode it follows the configured value.
// In adaptive mode it doubles or halves on each return to RUN, according to
// the length of the non-running stretch that just ended, then clamps to the bounds.
// Assumes: lo <= hi. idle_cnt is the stretch length minus one at the update edge.
module dpm_tau_adapt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adapt_en,
    input  logic          upd,
    input  logic [CW-1:0] tau_cfg,
    input  logic [CW-1:0] tau_lo,
    input  logic [CW-1:0] tau_hi,
    input  logic [CW-1:0] brk,
    input  logic [CW-1:0] idle_cnt,
    output logic [CW-1:0] tau_q
);
    localparam int WW = CW + 1;

    logic [WW-1:0] len_w;
    logic [WW-1:0] dbl_w;
    logic [WW-1:0] raw_w;
    logic [CW-1:0] tau_nxt;

    // Candidate value: doubled after a short stretch, halved after a long one.
    always_comb begin
        len_w = {1'b0, idle_cnt} + {{CW{1'b0}}, 1'b1};
        dbl_w = {tau_q, 1'b0};
        if (len_w < {1'b0, brk})
            raw_w = dbl_w;
        else if (len_w > dbl_w)
            raw_w = {2'b00, tau_q[CW-1:1]};
        else
            raw_w = {1'b0, tau_q};
        if (raw_w > {1'b0, tau_hi})
            tau_nxt = tau_hi;
        else if (raw_w < {1'b0, tau_lo})
            tau_nxt = tau_lo;
        else
            tau_nxt = raw_w[CW-1:0];
    end

    // Time-out register: track the configuration, or adapt on each update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tau_q <= tau_cfg;
        else if (!adapt_en)
            tau_q <= tau_cfg;
        else if (upd)
            tau_q <= tau_nxt;
    end
endmodule

// File: rtl/dpm_ctrl.sv
// Device power-state controller: RUN / IDLE / SHUT / SLEEP / WAKE.
// It applies a time-out or a predictive shutdown policy, counts the power-down
// and power-up intervals, and latches demand that arrives during power-down.
// Assumes: configuration inputs are steady while the device is outside RUN.
module dpm_ctrl #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          wake_i,
    input  logic          policy_i,
    input  logic          adapt_i,
    input  logic [CW-1:0] tau_i,
    input  logic [CW-1:0] tau_min_i,
    input  logic [CW-1:0] tau_max_i,
    input  logic [CW-1:0] brk_i,
    input  logic [CW-1:0] theta_i,
    input  logic [CW-1:0] tsd_i,
    input  logic [CW-1:0] twu_i,
    output logic          clk_en_o,
    output logic          pwr_en_o,
    output logic [2:0]    state_o,
    output logic          ready_o
);
    import dpm_pkg::*;

    dpm_state_e    state_q, state_d;
    logic [CW-1:0] busy_cnt, idle_cnt, dly_cnt, tau_q;
    logic          pend_q;

    // True when a counter that starts at 0 has completed lim cycles (0 acts as 1).
    function automatic logic reached(input logic [CW-1:0] cnt, input logic [CW-1:0] lim);
        logic [CW:0] c1;
        c1 = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
        return c1 >= {1'b0, lim};
    endfunction

    // Busy-run length: cycles in RUN with demand present.
    dpm_sat_ctr #(.W(CW)) u_busy (
        .clk(clk), .rst_n(rst_n),
        .clr(state_q != ST_RUN), .inc(req_i), .cnt(busy_cnt)
    );

    // Non-running stretch length: every cycle since RUN was left.
    dpm_sat_ctr #(.W(CW)) u_idle (
        .clk(clk), .rst_n(rst_n),
        .clr(state_q == ST_RUN), .inc(1'b1), .cnt(idle_cnt)
    );

    // Interval timer for SHUT and WAKE, restarted on every state change.
    dpm_sat_ctr #(.W(CW)) u_dly (
        .clk(clk), .rst_n(rst_n),
        .clr(state_d != state_q), .inc(1'b1), .cnt(dly_cnt)
    );

    // Time-out register, fixed or adaptive.
    dpm_tau_adapt #(.CW(CW)) u_tau (
        .clk(clk), .rst_n(rst_n), .adapt_en(adapt_i),
        .upd(state_q != ST_RUN && state_d == ST_RUN),
        .tau_cfg(tau_i), .tau_lo(tau_min_i), .tau_hi(tau_max_i),
        .brk(brk_i), .idle_cnt(idle_cnt), .tau_q(tau_q)
    );

    // Next-state decision for the policies and the timed intervals.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN: begin
                if (!req_i)
                    state_d = (policy_i && busy_cnt < theta_i) ? ST_SHUT : ST_IDLE;
            end
            ST_IDLE: begin
                if (req_i)
                    state_d = ST_RUN;
                else if (!policy_i && reached(idle_cnt, tau_q))
                    state_d = ST_SHUT;
            end
            ST_SHUT: begin
                if (reached(dly_cnt, tsd_i))
                    state_d = (pend_q || req_i) ? ST_WAKE : ST_SLEEP;
            end
            ST_SLEEP: begin
                if (req_i || wake_i)
                    state_d = ST_WAKE;
            end
            ST_WAKE: begin
                if (reached(dly_cnt, twu_i))
                    state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    // Pending-demand flag, held only while power-down continues.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (state_q == ST_SHUT && state_d == ST_SHUT)
            pend_q <= pend_q | req_i;
        else
            pend_q <= 1'b0;
    end

    // Output decode from the current state.
    always_comb begin
        state_o  = state_q;
        clk_en_o = (state_q == ST_RUN);
        ready_o  = (state_q == ST_RUN);
        pwr_en_o = (state_q != ST_SLEEP);
    end
endmodule

// File: rtl/dpm_ctrl_sva.sv
// Property checker for dpm_ctrl, attached by bind. It observes ports and the
// internal counters, and drives nothing.
// Assumes: configuration steady outside RUN, and tau_min_i <= tau_max_i.
module dpm_ctrl_sva #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_i,
    input logic          wake_i,
    input logic          policy_i,
    input logic          adapt_i,
    input logic [CW-1:0] tau_min_i,
    input logic [CW-1:0] tau_max_i,
    input logic [CW-1:0] theta_i,
    input logic [2:0]    state_o,
    input logic [CW-1:0] busy_cnt,
    input logic [CW-1:0] idle_cnt,
    input logic [CW-1:0] tau_q
);
    localparam logic [2:0] S_RUN = 3'd0, S_IDLE = 3'd1, S_SHUT = 3'd2,
                           S_SLEEP = 3'd3, S_WAKE = 3'd4;
    localparam logic [CW-1:0] C_MAX = '1;

    // R3: IDLE is kept until τ cycles have elapsed.
    a_r3_wait_tau: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_IDLE && !req_i && !policy_i &&
         ({1'b0, idle_cnt} + 1'b1) < {1'b0, tau_q}) |=> state_o == S_IDLE);

    // R4: demand in IDLE restores RUN at once.
    a_r4_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_IDLE && req_i) |=> state_o == S_RUN);

    // R6: SLEEP left on a wake event or demand, held otherwise.
    a_r6_sleep_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_SLEEP && (req_i || wake_i)) |=> state_o == S_WAKE);
    a_r6_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_SLEEP && !req_i && !wake_i) |=> state_o == S_SLEEP);

    // R7: demand during SHUT never ends in SLEEP.
    a_r7_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_SHUT && req_i) |=> state_o != S_SLEEP);

    // R8: a short busy run under the predictive policy goes straight to SHUT.
    a_r8_short_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_RUN && !req_i && policy_i && busy_cnt < theta_i) |=> state_o == S_SHUT);

    // R9: no time-out under the predictive policy.
    a_r9_no_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_IDLE && !req_i && policy_i) |=> state_o == S_IDLE);

    // R10: the adapted τ lies within the bounds after each update.
    a_r10_tau_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (adapt_i && $past(adapt_i) && $past(state_o) != S_RUN && state_o == S_RUN)
        |-> (tau_q >= tau_min_i && tau_q <= tau_max_i));

    // R12: the counters hold at the ceiling or clear, never wrap.
    a_r12_busy_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt == C_MAX) |=> (busy_cnt == C_MAX || busy_cnt == '0));
    a_r12_idle_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt == C_MAX) |=> (idle_cnt == C_MAX || idle_cnt == '0));
endmodule

bind dpm_ctrl dpm_ctrl_sva #(.CW(CW)) u_dpm_sva (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wake_i(wake_i),
    .policy_i(policy_i), .adapt_i(adapt_i), .tau_min_i(tau_min_i),
    .tau_max_i(tau_max_i), .theta_i(theta_i), .state_o(state_o),
    .busy_cnt(busy_cnt), .idle_cnt(idle_cnt), .tau_q(tau_q)
);

// File: tb/dpm_ctrl_bench.sv
// Scoreboard bench: the driver queues the expected state at a future edge count,
// and the monitor compares it and its decoded outputs at the falling edge.
module dpm_ctrl_bench;
    localparam int CW = 16;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n, req_i, wake_i, policy_i, adapt_i;
    logic [CW-1:0] tau_i, tau_min_i, tau_max_i, brk_i, theta_i, tsd_i, twu_i;
    logic          clk_en_o, pwr_en_o, ready_o;
    logic [2:0]    state_o;

    typedef struct {
        int         when;
        logic [2:0] st;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    dpm_ctrl #(.CW(CW)) u_dpm_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wake_i(wake_i),
        .policy_i(policy_i), .adapt_i(adapt_i), .tau_i(tau_i),
        .tau_min_i(tau_min_i), .tau_max_i(tau_max_i), .brk_i(brk_i),
        .theta_i(theta_i), .tsd_i(tsd_i), .twu_i(twu_i),
        .clk_en_o(clk_en_o), .pwr_en_o(pwr_en_o), .state_o(state_o),
        .ready_o(ready_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    // Compare outputs with the state code and the decode table of R2.
    task automatic check_state(logic [2:0] st, string tag);
        logic ec, ep, er;
        ec = (st == 3'd0);
        er = (st == 3'd0);
        ep = (st != 3'd3);
        checks++;
        if (state_o !== st || clk_en_o !== ec || pwr_en_o !== ep || ready_o !== er) begin
            errors++;
            $display("FAIL %s @%0d: state=%0d clk_en=%b pwr_en=%b ready=%b expected state=%0d clk_en=%b pwr_en=%b ready=%b",
                     tag, cyc, state_o, clk_en_o, pwr_en_o, ready_o, st, ec, ep, er);
        end
    endtask

    task automatic expect_in(int d, logic [2:0] st, string tag);
        q.push_back('{cyc + d, st, tag});
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: settle every expectation that has come due.
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].when <= cyc) begin
                check_state(q[i].st, q[i].tag);
                q.delete(i);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        for (int i = 0; i < WATCHDOG && !done; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Driver.
    initial begin
        rst_n = 1'b0; req_i = 1'b1; wake_i = 1'b0; policy_i = 1'b0; adapt_i = 1'b0;
        tau_i = 16'd4; tau_min_i = 16'd6; tau_max_i = 16'd16; brk_i = 16'd6;
        theta_i = 16'd5; tsd_i = 16'd3; twu_i = 16'd4;
        step(3);
        check_state(3'd0, "R1 reset");
        rst_n = 1'b1;
        expect_in(1, 3'd0, "R1 after reset");
        step(3);

        // Time-out path into SLEEP.
        req_i = 1'b0;
        expect_in(1, 3'd1, "R2 idle decode");
        expect_in(4, 3'd1, "R3 idle last cycle");
        expect_in(5, 3'd2, "R3 timeout to shut");
        expect_in(7, 3'd2, "R5 shut last cycle");
        expect_in(8, 3'd3, "R5 sleep");
        step(10);

        // Wake event out of SLEEP.
        wake_i = 1'b1;
        expect_in(1, 3'd4, "R6 wake start");
        expect_in(4, 3'd4, "R6 wake last cycle");
        expect_in(5, 3'd0, "R6 run after wake");
        step(1);
        wake_i = 1'b0;
        step(4);
        req_i = 1'b1;
        step(3);

        // IDLE left on demand.
        req_i = 1'b0;
        expect_in(1, 3'd1, "R4 idle");
        step(2);
        req_i = 1'b1;
        expect_in(1, 3'd0, "R4 immediate run");
        step(3);

        // Demand pulse during SHUT.
        req_i = 1'b0;
        expect_in(5, 3'd2, "R7 shut");
        step(6);
        req_i = 1'b1;
        expect_in(1, 3'd2, "R7 shut holds, not ready");
        step(1);
        req_i = 1'b0;
        expect_in(1, 3'd4, "R7 pending wake");
        expect_in(4, 3'd4, "R7 wake last cycle");
        expect_in(5, 3'd0, "R7 run");
        step(5);
        req_i = 1'b1;
        step(8);

        // Predictive policy: long busy run, no time-out.
        policy_i = 1'b1;
        step(1);
        req_i = 1'b0;
        expect_in(1, 3'd1, "R9 idle after long busy");
        expect_in(15, 3'd1, "R9 no timeout");
        step(16);
        req_i = 1'b1;
        expect_in(1, 3'd0, "R4 run");
        step(2);
        req_i = 1'b0;
        expect_in(1, 3'd2, "R8 immediate shut");
        expect_in(4, 3'd3, "R8 sleep");
        step(6);
        req_i = 1'b1;
        expect_in(1, 3'd4, "R6 request wakes sleep");
        expect_in(5, 3'd0, "R6 run");
        step(10);
        req_i = 1'b0;
        expect_in(1, 3'd1, "R9 busy equal theta stays awake");
        step(3);
        req_i = 1'b1;
        step(2);
        policy_i = 1'b0;

        // Adaptive τ: three short idles take 4 to 8 to 16 (capped).
        adapt_i = 1'b1;
        step(1);
        for (int k = 0; k < 3; k++) begin
            req_i = 1'b0;
            step(1);
            req_i = 1'b1;
            step(2);
        end
        step(1);
        req_i = 1'b0;
        expect_in(16, 3'd1, "R10 tau doubled to cap");
        expect_in(17, 3'd2, "R10 timeout at 16");
        step(40);
        wake_i = 1'b1;
        expect_in(5, 3'd0, "R6 run");
        step(1);
        wake_i = 1'b0;
        step(4);
        req_i = 1'b1;
        step(2);

        // Long stretch halved 16 to 8.
        req_i = 1'b0;
        expect_in(8, 3'd1, "R11 tau halved");
        expect_in(9, 3'd2, "R11 timeout at 8");
        step(30);
        wake_i = 1'b1;
        step(1);
        wake_i = 1'b0;
        step(4);
        req_i = 1'b1;
        step(2);

        // Halving 8 to 4 is raised to the lower bound 6.
        req_i = 1'b0;
        expect_in(6, 3'd1, "R11 tau floored");
        expect_in(7, 3'd2, "R11 timeout at 6");
        step(12);
        wake_i = 1'b1;
        expect_in(5, 3'd0, "R6 run");
        step(1);
        wake_i = 1'b0;
        step(4);

        // Busy counter saturation: θ at all ones, a run longer than the counter range.
        req_i = 1'b1;
        adapt_i = 1'b0;
        policy_i = 1'b1;
        theta_i = 16'hFFFF;
        step(65540);
        req_i = 1'b0;
        expect_in(1, 3'd1, "R12 saturated busy keeps device awake");
        step(3);

        if (q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule